// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Handling

This block is the integer execute stage of a small 32-bit load/store core. Each cycle it may accept two register operands, a 16-bit immediate taken from the instruction word, a 5-bit shift count and a 4-bit operation code. One clock edge later it presents a 32-bit result, together with a flag that tells a branch unit whether the two register operands were equal.

The immediate is widened in a way that depends on the operation. Arithmetic and compare forms sign-extend it. The logical immediate form zero-extends it. The upper-load form moves it into the top half of the word. The unit also has a NOR operation and signed and unsigned set-on-less-than operations, which return the word 0 or 1. Sums and differences wrap around without a trap. The register file supplies a constant-zero operand, so software gets a register copy by adding zero.

Top module: `alu_exec32`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `eq_flag` are all 0.
- R2: An operation accepted with `in_valid` high at a rising edge shows up on `result` and `eq_flag`, with `out_valid` high, right after that edge. At an edge where `in_valid` is low, `out_valid` drops to 0 and `result` and `eq_flag` keep their values.
- R3: Op 0 (add) returns `src_a + src_b` and op 1 (sub) returns `src_a - src_b`, both modulo 2^32 with no trap. Adding a zero `src_b` returns `src_a` unchanged, which is the register copy.
- R4: Op 2 (add-immediate) returns `src_a` plus `imm` sign-extended from bit 15.
- R5: Op 3 (and), op 4 (or) and op 5 (nor) act bitwise on `src_a` and `src_b`. Nor returns the inverse of the OR, so nor with a zero operand returns the bitwise NOT of the other operand.
- R6: Op 6 (or-immediate) returns `src_a` ORed with `imm` zero-extended, so bits 31:16 of the result equal those of `src_a`.
- R7: Op 7 (shift-left-logical) returns `src_b` shifted left by `shamt` (0 to 31), filling the vacated bits with zeros.
- R8: Op 8 (signed less-than), op 9 (unsigned less-than) and op 10 (signed less-than against the sign-extended `imm`) each return 1 when `src_a` is less than the second operand and 0 otherwise. Bits 31:1 of the result are always 0.
- R9: Op 11 (load-upper) returns `imm` in bits 31:16 and zeros in bits 15:0, whatever the operands are.
- R10: `eq_flag` is 1 exactly when `src_a == src_b` for the accepted operation, whatever the op code, and it is registered in the same cycle as `result`.
- R11: Op codes 12 to 15 are unused, and they return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation presented this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Shift count for shift-left-logical |
| out_valid | output | 1 | Result registered from an accepted operation |
| result | output | 32 | Registered result |
| eq_flag | output | 1 | Registered operand equality for branches |

## Verification
The assertions assume that `op_sel`, the operands, `imm` and `shamt` are stable and known at every rising edge where `in_valid` is high. They also assume that `rst_n` goes high away from a clock edge. The bench meets both conditions by changing every input only on falling edges and by holding reset over several cycles. The hold checks depend on the block ignoring inputs that change while `in_valid` is low. For this reason the bench deliberately scrambles the operands during idle cycles, and the outputs are then expected to stay the same.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDI = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_NOR  = 4'd5,
    OP_ORI  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLTI = 4'd10,
    OP_LUI  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_mode_e;
endpackage

// File: rtl/alu_immext.sv
module alu_immext
  import alu_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_W  = alu_pkg::IMM_W
) (
  input  alu_op_e           op,
  input  logic [IMM_W-1:0]  imm,
  output ext_mode_e         mode,
  output logic [DATA_W-1:0] immx
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    case (op)
      OP_ORI:  mode = EXT_ZERO;
      OP_LUI:  mode = EXT_UPPER;
      default: mode = EXT_SIGN;
    endcase
  end

  always_comb begin
    case (mode)
      EXT_ZERO:  immx = {{PAD_W{1'b0}}, imm};
      EXT_UPPER: immx = {imm, {PAD_W{1'b0}}};
      default:   immx = {{PAD_W{imm[IMM_W-1]}}, imm};
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W  = XLEN,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [DATA_W-1:0]  immx,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  res,
  output logic               eq
);
  function automatic logic [DATA_W-1:0] f_wrap_add(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic neg);
    logic [DATA_W-1:0] yy;
    yy = neg ? (~y + 1'b1) : y;
    return x + yy;
  endfunction

  function automatic logic [DATA_W-1:0] f_less(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic sgn);
    logic lt;
    lt = sgn ? ($signed(x) < $signed(y)) : (x < y);
    return {{(DATA_W-1){1'b0}}, lt};
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  res = f_wrap_add(opa, opb, 1'b0);
      OP_SUB:  res = f_wrap_add(opa, opb, 1'b1);
      OP_ADDI: res = f_wrap_add(opa, immx, 1'b0);
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_NOR:  res = ~(opa | opb);
      OP_ORI:  res = opa | immx;
      OP_SLL:  res = opb << shamt;
      OP_SLT:  res = f_less(opa, opb, 1'b1);
      OP_SLTU: res = f_less(opa, opb, 1'b0);
      OP_SLTI: res = f_less(opa, immx, 1'b1);
      OP_LUI:  res = immx;
      default: res = '0;
    endcase
  end

  assign eq = (opa == opb);
endmodule

// File: rtl/alu_exec32.sv
module alu_exec32
  import alu_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_W  = alu_pkg::IMM_W,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OP_W-1:0]    op_sel,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               eq_flag
);
  alu_op_e           op_w;
  ext_mode_e         ext_mode_w;
  logic [DATA_W-1:0] immx_w;
  logic [DATA_W-1:0] comb_res_w;
  logic              comb_eq_w;
  logic              is_cmp_w;
  logic              is_unused_w;

  assign op_w        = alu_op_e'(op_sel);
  assign is_cmp_w    = (op_sel == OP_SLT) || (op_sel == OP_SLTU) || (op_sel == OP_SLTI);
  assign is_unused_w = (op_sel > OP_LUI);

  alu_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .op   (op_w),
    .imm  (imm),
    .mode (ext_mode_w),
    .immx (immx_w)
  );

  alu_core #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_core (
    .op    (op_w),
    .opa   (src_a),
    .opb   (src_b),
    .immx  (immx_w),
    .shamt (shamt),
    .res   (comb_res_w),
    .eq    (comb_eq_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      eq_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= comb_res_w;
        eq_flag <= comb_eq_w;
      end
    end
  end

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!out_valid && result == '0 && !eq_flag);
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(eq_flag)));
  p_cmp_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp_w) |=> (result[DATA_W-1:1] == '0));
  p_lui_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_LUI) |=> (result[DATA_W-IMM_W-1:0] == '0));
  p_lui_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_LUI) |-> (ext_mode_w == EXT_UPPER));
  p_ori_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ORI) |-> (immx_w[DATA_W-1:IMM_W] == '0));
  p_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (eq_flag == ($past(src_a) == $past(src_b))));
  p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_unused_w) |=> (result == '0));
endmodule

// File: tb/alu_exec32_test.sv
module alu_exec32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid, eq_flag;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  alu_exec32 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .out_valid(out_valid), .result(result), .eq_flag(eq_flag)
  );

  // Independent reference written from the requirements.
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] sx, zx;
    logic        slt_ab, slt_ai;
    sx = {{16{im[15]}}, im};
    zx = {16'h0000, im};
    slt_ab = (a[31] != b[31]) ? a[31] : (a < b);
    slt_ai = (a[31] != sx[31]) ? a[31] : (a < sx);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a + ~b + 32'd1;
      4'd2:  return a + sx;
      4'd3:  return a & b;
      4'd4:  return a | b;
      4'd5:  return ~a & ~b;
      4'd6:  return a | zx;
      4'd7:  return 32'(64'(b) << sh);
      4'd8:  return {31'd0, slt_ab};
      4'd9:  return {31'd0, (a < b)};
      4'd10: return {31'd0, slt_ai};
      4'd11: return {im, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm = im; shamt = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "out_valid after accept", {31'd0, out_valid}, 32'd1);
    check(req, $sformatf("result op %0d", op), result, model(op, a, b, im, sh));
    check("R10", "eq_flag", {31'd0, eq_flag}, {31'd0, (a == b)});
  endtask

  task automatic t_reset_r1;
    check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1", "result in reset", result, 32'd0);
    check("R1", "eq_flag in reset", {31'd0, eq_flag}, 32'd0);
  endtask

  task automatic t_addsub_r3;
    run_op("R3", 4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
    run_op("R3", 4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 5'd0);
    run_op("R3", 4'd0, 32'hDEAD_BEEF, 32'h0000_0000, 16'h0, 5'd0);
    check("R3", "move via add zero", result, 32'hDEAD_BEEF);
    run_op("R3", 4'd1, 32'd5, 32'd7, 16'h0, 5'd0);
    run_op("R3", 4'd1, 32'd0, 32'd1, 16'h0, 5'd0);
    check("R3", "0-1 wraps", result, 32'hFFFF_FFFF);
  endtask

  task automatic t_addi_r4;
    run_op("R4", 4'd2, 32'd10, 32'h1234, 16'hFFFF, 5'd0);
    check("R4", "10 + (-1)", result, 32'd9);
    run_op("R4", 4'd2, 32'd1, 32'd0, 16'h7FFF, 5'd0);
    run_op("R4", 4'd2, 32'h0001_0000, 32'd0, 16'h8000, 5'd0);
  endtask

  task automatic t_logic_r5;
    run_op("R5", 4'd3, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0);
    run_op("R5", 4'd4, 32'hF000_000F, 32'h0F00_00F0, 16'h0, 5'd0);
    run_op("R5", 4'd5, 32'hA5A5_0000, 32'h0000_5A5A, 16'h0, 5'd0);
    run_op("R5", 4'd5, 32'h1234_5678, 32'h0, 16'h0, 5'd0);
    check("R5", "nor with zero is NOT", result, 32'hEDCB_A987);
  endtask

  task automatic t_ori_r6;
    run_op("R6", 4'd6, 32'h0000_0000, 32'd0, 16'h8001, 5'd0);
    check("R6", "ori zero-extends", result, 32'h0000_8001);
    run_op("R6", 4'd6, 32'hABCD_0F00, 32'd0, 16'hF00F, 5'd0);
  endtask

  task automatic t_sll_r7;
    run_op("R7", 4'd7, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd31);
    check("R7", "1<<31", result, 32'h8000_0000);
    run_op("R7", 4'd7, 32'd0, 32'h0F00_0001, 16'h0, 5'd4);
    run_op("R7", 4'd7, 32'd0, 32'hCAFE_F00D, 16'h0, 5'd0);
  endtask

  task automatic t_slt_r8;
    run_op("R8", 4'd8, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    check("R8", "signed -1<1", result, 32'd1);
    run_op("R8", 4'd9, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    check("R8", "unsigned max<1", result, 32'd0);
    run_op("R8", 4'd9, 32'd3, 32'h8000_0000, 16'h0, 5'd0);
    run_op("R8", 4'd8, 32'd7, 32'd7, 16'h0, 5'd0);
    run_op("R8", 4'd10, 32'hFFFF_FFFB, 32'd0, 16'hFFFE, 5'd0);
    check("R8", "slti -5<-2", result, 32'd1);
    run_op("R8", 4'd10, 32'd3, 32'd0, 16'h0003, 5'd0);
    run_op("R8", 4'd10, 32'd0, 32'd0, 16'h8000, 5'd0);
  endtask

  task automatic t_lui_r9;
    run_op("R9", 4'd11, 32'h1111_2222, 32'h3333_4444, 16'hABCD, 5'd9);
    check("R9", "lui placement", result, 32'hABCD_0000);
  endtask

  task automatic t_unused_r11;
    run_op("R11", 4'd12, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 5'd3);
    run_op("R11", 4'd15, 32'h1234_5678, 32'h1234_5678, 16'h1, 5'd1);
    check("R11", "unused code zero", result, 32'd0);
  endtask

  task automatic t_equal_r10;
    run_op("R10", 4'd3, 32'h5555_AAAA, 32'h5555_AAAA, 16'h0, 5'd0);
    check("R10", "equal flag set", {31'd0, eq_flag}, 32'd1);
    run_op("R10", 4'd11, 32'h5555_AAAA, 32'h5555_AAAB, 16'h0001, 5'd0);
    check("R10", "equal flag clear", {31'd0, eq_flag}, 32'd0);
  endtask

  task automatic t_hold_r2;
    logic [31:0] keep;
    run_op("R2", 4'd0, 32'd40, 32'd2, 16'h0, 5'd0);
    keep = result;
    @(negedge clk);
    op_sel = 4'd1; src_a = 32'hFFFF_0000; src_b = 32'hFFFF_0000; imm = 16'h5; shamt = 5'd2;
    @(negedge clk);
    @(negedge clk);
    check("R2", "out_valid low when idle", {31'd0, out_valid}, 32'd0);
    check("R2", "result held when idle", result, keep);
    check("R2", "eq_flag held when idle", {31'd0, eq_flag}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_addsub_r3();
    t_addi_r4();
    t_logic_r5();
    t_ori_r6();
    t_sll_r7();
    t_slt_r8();
    t_lui_r9();
    t_unused_r11();
    t_equal_r10();
    t_hold_r2();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule